// File: doc/BRIEF.md
# Overlay Memory Block Mapper

This block steers each bus cycle of an emulated processor to one of three memories: the target system's own memory, the emulator's shadow memory, or the emulator's overlay memory. It also rewrites the address at 16 KB block granularity. The address splits into a 14-bit offset and an 18-bit block number. The low bits of the block number index a mapper table. Each table entry holds a replacement block number and a 2-bit route code. The offset is never altered. The overlay memory is 1 MB, so an overlay-routed cycle may only name one of 64 overlay blocks.

A host-side port programs the table. It does so only while the processor is halted, so that a running program never sees its memory map change under it. A write attempted while the processor runs is dropped and reported. The processor-side lookup is registered. The translated address, the three chip selects and the error flag all appear together one clock after the cycle is presented.

After reset every entry holds its own index and routes to target memory, so the mapper starts as an identity mapping. The table depth is a parameter. A reduced depth keeps simulation small. In that case, block-number bits above the indexed field are ignored, so those addresses alias onto the indexed entries.

Top module: `ovl_block_mapper`

## Requirements
- R1: During and directly after reset, `outValid`, all three selects, `mapErr` and `wrReject` are 0. Every table entry holds its own index as block number, with route code 00.
- R2: A cycle presented with `busValid`=1 produces `outValid`=1 exactly one clock later. In that same clock, `outAddr` bits [31:14] equal the block number of the entry indexed by `busAddr[14+MAP_IDX_W-1:14]`.
- R3: `outAddr[13:0]` equals `busAddr[13:0]` of the same cycle. The offset is never translated.
- R4: Route codes are 00 = target, 01 = overlay, 10 = shadow, and 11 = reserved, which is treated as target. For a valid cycle with no error, exactly the one matching select of `selTarget`, `selShadow`, `selOverlay` is 1. When `outValid` is 0, no select is 1.
- R5: For an overlay-routed cycle, `ovlAddr` is {block[5:0], offset}. If block bits [17:6] are not all zero, `mapErr` is 1 and no select is asserted.
- R6: A host write (`hostWe`=1) while `cpuHalted`=1 replaces the indexed entry's block number and route. A lookup in the same cycle still sees the old entry. Lookups from the next cycle on see the new one.
- R7: A host write while `cpuHalted`=0 leaves the table unchanged, and `wrReject` is 1 in the following cycle.
- R8: An entry holding its own index with route 00 returns the address unchanged in bits [14+MAP_IDX_W-1:0], with zeros above. Bus address bits above the indexed field do not affect the lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuHalted | input | 1 | Processor is halted; host writes allowed |
| hostWe | input | 1 | Host table write strobe |
| hostIdx | input | MAP_IDX_W | Table entry to write |
| hostBlk | input | 18 | Replacement block number to store |
| hostRoute | input | 2 | Route code to store |
| busValid | input | 1 | Processor bus cycle present |
| busAddr | input | 32 | Processor address |
| outValid | output | 1 | Registered lookup result valid |
| outAddr | output | 32 | Translated address |
| ovlAddr | output | 20 | Address inside the 1 MB overlay memory |
| selTarget | output | 1 | Target memory chip select |
| selShadow | output | 1 | Shadow memory chip select |
| selOverlay | output | 1 | Overlay memory chip select |
| mapErr | output | 1 | Overlay block number out of range |
| wrReject | output | 1 | Previous-cycle host write was dropped |

## Verification
The assertions check several properties on every cycle. The chip selects are never more than one-hot, and none is asserted without a valid result. `outValid` and `wrReject` follow their causes by exactly one clock. The offset passes through unchanged. A mapping error never coincides with a select. The overlay address agrees with the translated block. Whether a lookup returns the right entry depends on the whole write history: accepted writes, rejected writes, same-cycle write and lookup, and aliasing at reduced depth. Only the bench's scenarios, checked against a table model, can show that.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [1:0] {
    RT_TARGET  = 2'b00,
    RT_OVERLAY = 2'b01,
    RT_SHADOW  = 2'b10,
    RT_RSVD    = 2'b11
  } route_e;

  // strobes from control to datapath
  typedef struct packed {
    logic lookupEn;
    logic wrEn;
    logic wrDrop;
  } mapCtrl_t;

endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuHalted,
  input  logic     hostWe,
  input  logic     busValid,
  output mapCtrl_t ctrl,
  output logic     wrReject
);

  always_comb begin
    ctrl.lookupEn = busValid;
    ctrl.wrEn     = hostWe & cpuHalted;
    ctrl.wrDrop   = hostWe & ~cpuHalted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wrReject <= 1'b0;
    else       wrReject <= ctrl.wrDrop;
  end

endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import mapper_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 14,
  parameter int BLK_W     = ADDR_W - OFS_W,
  parameter int OVL_BLK_W = 6,
  parameter int MAP_IDX_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mapCtrl_t                 ctrl,
  input  logic [MAP_IDX_W-1:0]     hostIdx,
  input  logic [BLK_W-1:0]         hostBlk,
  input  logic [1:0]               hostRoute,
  input  logic [ADDR_W-1:0]        busAddr,
  output logic                     outValid,
  output logic [ADDR_W-1:0]        outAddr,
  output logic [OVL_BLK_W+OFS_W-1:0] ovlAddr,
  output logic                     selTarget,
  output logic                     selShadow,
  output logic                     selOverlay,
  output logic                     mapErr
);

  localparam int DEPTH = 1 << MAP_IDX_W;

  logic [BLK_W-1:0] blkMem   [DEPTH];
  logic [1:0]       routeMem [DEPTH];

  // table entries: reset to identity, target route
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        blkMem[g]   <= BLK_W'(g);
        routeMem[g] <= RT_TARGET;
      end else if (ctrl.wrEn && (hostIdx == MAP_IDX_W'(g))) begin
        blkMem[g]   <= hostBlk;
        routeMem[g] <= hostRoute;
      end
    end
  end

  logic [MAP_IDX_W-1:0] lookIdx;
  logic [BLK_W-1:0]     entBlk;
  route_e               entRoute;
  logic                 upperNz;
  logic                 nTgt, nShd, nOvl, nErr;
  logic [OFS_W-1:0]     offs;

  always_comb begin
    lookIdx  = busAddr[OFS_W +: MAP_IDX_W];
    offs     = busAddr[OFS_W-1:0];
    entBlk   = blkMem[lookIdx];
    entRoute = route_e'(routeMem[lookIdx]);
    upperNz  = |entBlk[BLK_W-1:OVL_BLK_W];
    nTgt = 1'b0;
    nShd = 1'b0;
    nOvl = 1'b0;
    nErr = 1'b0;
    unique case (entRoute)
      RT_OVERLAY: begin
        nErr = ctrl.lookupEn & upperNz;
        nOvl = ctrl.lookupEn & ~upperNz;
      end
      RT_SHADOW: nShd = ctrl.lookupEn;
      RT_TARGET, RT_RSVD: nTgt = ctrl.lookupEn;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outAddr    <= '0;
      ovlAddr    <= '0;
      selTarget  <= 1'b0;
      selShadow  <= 1'b0;
      selOverlay <= 1'b0;
      mapErr     <= 1'b0;
    end else begin
      outValid   <= ctrl.lookupEn;
      outAddr    <= {entBlk, offs};
      ovlAddr    <= {entBlk[OVL_BLK_W-1:0], offs};
      selTarget  <= nTgt;
      selShadow  <= nShd;
      selOverlay <= nOvl;
      mapErr     <= nErr;
    end
  end

endmodule

// File: rtl/ovl_block_mapper.sv
module ovl_block_mapper
  import mapper_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 14,
  parameter int OVL_BLK_W = 6,
  parameter int MAP_IDX_W = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cpuHalted,
  input  logic                         hostWe,
  input  logic [MAP_IDX_W-1:0]         hostIdx,
  input  logic [ADDR_W-OFS_W-1:0]      hostBlk,
  input  logic [1:0]                   hostRoute,
  input  logic                         busValid,
  input  logic [ADDR_W-1:0]            busAddr,
  output logic                         outValid,
  output logic [ADDR_W-1:0]            outAddr,
  output logic [OVL_BLK_W+OFS_W-1:0]   ovlAddr,
  output logic                         selTarget,
  output logic                         selShadow,
  output logic                         selOverlay,
  output logic                         mapErr,
  output logic                         wrReject
);

  localparam int BLK_W = ADDR_W - OFS_W;

  mapCtrl_t ctrl;

  mapper_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuHalted (cpuHalted),
    .hostWe    (hostWe),
    .busValid  (busValid),
    .ctrl      (ctrl),
    .wrReject  (wrReject)
  );

  mapper_datapath #(
    .ADDR_W    (ADDR_W),
    .OFS_W     (OFS_W),
    .BLK_W     (BLK_W),
    .OVL_BLK_W (OVL_BLK_W),
    .MAP_IDX_W (MAP_IDX_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .hostIdx    (hostIdx),
    .hostBlk    (hostBlk),
    .hostRoute  (hostRoute),
    .busAddr    (busAddr),
    .outValid   (outValid),
    .outAddr    (outAddr),
    .ovlAddr    (ovlAddr),
    .selTarget  (selTarget),
    .selShadow  (selShadow),
    .selOverlay (selOverlay),
    .mapErr     (mapErr)
  );

endmodule

// File: rtl/mapper_chk.sv
module mapper_chk #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 14,
  parameter int OVL_BLK_W = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cpuHalted,
  input logic                       hostWe,
  input logic                       busValid,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       outValid,
  input logic [ADDR_W-1:0]          outAddr,
  input logic [OVL_BLK_W+OFS_W-1:0] ovlAddr,
  input logic                       selTarget,
  input logic                       selShadow,
  input logic                       selOverlay,
  input logic                       mapErr,
  input logic                       wrReject
);

  logic warm;
  always_ff @(posedge clk) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selTarget, selShadow, selOverlay}));

  // R4
  sel_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(selTarget | selShadow | selOverlay | mapErr));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN || !warm)
    outValid == $past(busValid));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN || !warm)
    outValid |-> outAddr[OFS_W-1:0] == $past(busAddr[OFS_W-1:0]));

  // R5
  err_no_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapErr |-> !(selTarget | selShadow | selOverlay));

  // R5
  ovl_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    selOverlay |-> (ovlAddr == outAddr[OVL_BLK_W+OFS_W-1:0]
                    && outAddr[ADDR_W-1:OVL_BLK_W+OFS_W] == '0));

  // R7
  reject_latency_chk: assert property (@(posedge clk) disable iff (!rstN || !warm)
    wrReject == $past(hostWe && !cpuHalted));

endmodule

bind ovl_block_mapper mapper_chk #(
  .ADDR_W    (ADDR_W),
  .OFS_W     (OFS_W),
  .OVL_BLK_W (OVL_BLK_W)
) uChk (.*);

// File: tb/sim_ovl_block_mapper.sv
`timescale 1ns/1ps
module sim_ovl_block_mapper;

  localparam int IW = 8;
  localparam int DEPTH = 1 << IW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuHalted = 1'b0;
  logic        hostWe = 1'b0;
  logic [IW-1:0] hostIdx = '0;
  logic [17:0] hostBlk = '0;
  logic [1:0]  hostRoute = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic        outValid;
  logic [31:0] outAddr;
  logic [19:0] ovlAddr;
  logic        selTarget, selShadow, selOverlay, mapErr, wrReject;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [17:0] mBlk [DEPTH];
  logic [1:0]  mRoute [DEPTH];

  always #2.5 clk = ~clk;

  ovl_block_mapper #(.MAP_IDX_W(IW)) u0 (
    .clk(clk), .rstN(rstN), .cpuHalted(cpuHalted), .hostWe(hostWe),
    .hostIdx(hostIdx), .hostBlk(hostBlk), .hostRoute(hostRoute),
    .busValid(busValid), .busAddr(busAddr), .outValid(outValid),
    .outAddr(outAddr), .ovlAddr(ovlAddr), .selTarget(selTarget),
    .selShadow(selShadow), .selOverlay(selOverlay), .mapErr(mapErr),
    .wrReject(wrReject)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expSel(input bit v, input logic [1:0] r, input logic [17:0] b);
    // {target, shadow, overlay}
    if (!v) return 3'b000;
    if (r == 2'b01) return (b[17:6] != 0) ? 3'b000 : 3'b001;
    if (r == 2'b10) return 3'b010;
    return 3'b100;
  endfunction

  // drive one cycle (called at a negedge), check the result one negedge later
  task automatic step(input bit halt, input bit we, input logic [IW-1:0] idx,
                      input logic [17:0] blk, input logic [1:0] rt,
                      input bit v, input logic [31:0] addr);
    logic [IW-1:0] li;
    logic [17:0] eb;
    logic [1:0] er;
    logic [2:0] es;
    bit eErr;
    cpuHalted = halt; hostWe = we; hostIdx = idx; hostBlk = blk; hostRoute = rt;
    busValid = v; busAddr = addr;
    li = addr[14 +: IW];
    eb = mBlk[li];
    er = mRoute[li];
    es = expSel(v, er, eb);
    eErr = v && (er == 2'b01) && (eb[17:6] != 0);
    if (we && halt) begin
      mBlk[idx] = blk;
      mRoute[idx] = rt;
    end
    @(negedge clk);
    chk(outValid == v, "R2 outValid", 64'(outValid), 64'(v));
    if (v) begin
      chk(outAddr[31:14] == eb, "R2 block", 64'(outAddr[31:14]), 64'(eb));
      chk(outAddr[13:0] == addr[13:0], "R3 offset", 64'(outAddr[13:0]), 64'(addr[13:0]));
      if (es == 3'b001)
        chk(ovlAddr == {eb[5:0], addr[13:0]}, "R5 ovlAddr", 64'(ovlAddr), 64'({eb[5:0], addr[13:0]}));
    end
    chk({selTarget, selShadow, selOverlay} == es, "R4 selects",
        64'({selTarget, selShadow, selOverlay}), 64'(es));
    chk(mapErr == eErr, "R5 mapErr", 64'(mapErr), 64'(eErr));
    chk(wrReject == (we && !halt), "R7 wrReject", 64'(wrReject), 64'(we && !halt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      mBlk[i] = 18'(i);
      mRoute[i] = 2'b00;
    end
    repeat (4) @(negedge clk);
    // R1: outputs quiet in reset
    chk({outValid, selTarget, selShadow, selOverlay, mapErr, wrReject} == 6'b0,
        "R1 reset outputs", 64'({outValid, selTarget, selShadow, selOverlay, mapErr, wrReject}), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk({outValid, selTarget, selShadow, selOverlay, mapErr, wrReject} == 6'b0,
        "R1 after reset", 64'({outValid, selTarget, selShadow, selOverlay, mapErr, wrReject}), 64'(0));

    // R8 / R1: identity table after reset, upper bits alias
    step(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, 32'h0012_3456);
    chk(outAddr == {10'b0, 22'h12_3456}, "R8 identity", 64'(outAddr), 64'({10'b0, 22'h12_3456}));
    chk(selTarget, "R1 default route target", 64'(selTarget), 64'(1));
    step(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, 32'hFFD2_3456);
    chk(outAddr == {10'b0, 22'h12_3456}, "R8 alias upper bits", 64'(outAddr), 64'({10'b0, 22'h12_3456}));

    // R6: halted write, same-cycle lookup sees old entry
    step(1'b1, 1'b1, 8'd5, 18'h00003, 2'b01, 1'b1, {10'b0, 8'd5, 14'h0ABC});
    chk(selTarget && !selOverlay, "R6 same-cycle old entry", 64'({selTarget, selOverlay}), 64'(2'b10));
    step(1'b1, 1'b0, '0, '0, 2'b00, 1'b1, {10'b0, 8'd5, 14'h0ABC});
    chk(selOverlay && ovlAddr == {6'd3, 14'h0ABC}, "R6 new entry used",
        64'({selOverlay, ovlAddr}), 64'({1'b1, 6'd3, 14'h0ABC}));

    // R7: write while running dropped
    step(1'b0, 1'b1, 8'd6, 18'h2_0000, 2'b10, 1'b0, '0);
    step(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, {10'b0, 8'd6, 14'h0001});
    chk(selTarget && outAddr[31:14] == 18'd6, "R7 table unchanged",
        64'({selTarget, outAddr[31:14]}), 64'({1'b1, 18'd6}));

    // R5: overlay with out-of-range block
    step(1'b1, 1'b1, 8'd7, 18'h0_0040, 2'b01, 1'b0, '0);
    step(1'b1, 1'b0, '0, '0, 2'b00, 1'b1, {10'b0, 8'd7, 14'h0002});
    chk(mapErr && !selOverlay, "R5 range error", 64'({mapErr, selOverlay}), 64'(2'b10));

    // R4: shadow and reserved routes
    step(1'b1, 1'b1, 8'd8, 18'h1_2345, 2'b10, 1'b0, '0);
    step(1'b1, 1'b1, 8'd9, 18'h0_0777, 2'b11, 1'b1, {10'b0, 8'd8, 14'h0003});
    chk(selShadow, "R4 shadow route", 64'(selShadow), 64'(1));
    step(1'b1, 1'b0, '0, '0, 2'b00, 1'b1, {10'b0, 8'd9, 14'h0004});
    chk(selTarget && outAddr[31:14] == 18'h0_0777, "R4 reserved as target",
        64'({selTarget, outAddr[31:14]}), 64'({1'b1, 18'h0_0777}));

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [17:0] b;
      b = ($urandom % 2 == 0) ? {12'b0, 6'($urandom)} : 18'($urandom);
      step(($urandom % 3) != 0, ($urandom % 4) == 0, IW'($urandom), b,
           2'($urandom), ($urandom % 5) != 0, $urandom);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule